// File: doc/BRIEF.md
# Parallel Configuration Ingress: Bit-Swap and Sync Hunter

This block is the first stage behind a parallel configuration port. Each clock it may take one bus unit: one byte in narrow mode or one 16-bit halfword in wide mode. It reverses the bit order inside every byte, because the bus carries each byte with its most significant bit on data line 0. It then looks for the 32-bit synchronization pattern `0xAA995566` and passes nothing downstream until it has found it.

Before sync, every accepted unit is shifted into a 32-bit sliding window. The window is compared with the pattern on each accepted unit, so the pattern is found at any byte or halfword offset. Once sync is found, the units that follow are packed into 32-bit words on boundaries that start right after the pattern. The first unit of each word becomes its most significant part. Each complete word is presented on a valid/ready output. The pattern itself is never forwarded.

Flow control works as follows. Input units are offered with `in_valid` and taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while a finished word is waiting and `out_ready` is low. A word on the output keeps its value until the edge where `out_valid` and `out_ready` are both high. `wide_mode` is a static control: it must be held steady from reset onwards. `synced` is a plain status output.

Top module: `cfgport_ingress`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `synced` and `out_valid` to 0; after reset `in_ready` is 1.
- R2: In narrow mode (`wide_mode`=0) only `in_data[7:0]` is used; bus bit i maps to logical bit 7-i of the byte (line 0 is the MSB).
- R3: In wide mode (`wide_mode`=1) the same reversal is applied separately to `in_data[15:8]` and `in_data[7:0]`; the upper byte is the more significant logical byte.
- R4: In narrow mode, `synced` goes to 1 on the edge that accepts the last of the bus bytes 0x55, 0x99, 0xAA, 0x66 taken in that order; any number of earlier bytes, including partial matches, may come before them.
- R5: In wide mode, `synced` goes to 1 on the edge that accepts bus halfword 0xAA66 directly after accepted halfword 0x5599, at any halfword offset.
- R6: The sync pattern is not forwarded: `out_valid` stays 0 through and immediately after the edge that sets `synced`.
- R7: After sync, a word is complete after 4 accepted units (narrow) or 2 accepted units (wide). The first unit goes to `out_data[31:24]` (narrow) or `out_data[31:16]` (wide). `out_valid` is 1 in the cycle after the edge that accepts the last unit.
- R8: Cycles in which no unit is accepted (`in_valid` low, or `in_ready` low) change neither the window nor the word being assembled.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data` and `out_valid` hold their values; `out_valid` clears on the edge where `out_ready` is 1, unless a new word completes on that same edge.
- R10: Once set, `synced` stays 1 until reset; after sync the pattern is treated as ordinary data and forwarded as the word 0xAA995566.
- R11: `out_valid` is never 1 while `synced` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 0 = byte bus, 1 = halfword bus; held static |
| in_valid | input | 1 | Bus unit present (chip-enable) |
| in_ready | output | 1 | Unit can be accepted this cycle |
| in_data | input | 16 | Bus unit; narrow mode uses bits [7:0] |
| out_valid | output | 1 | Assembled word present |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Assembled word in logical bit order |
| synced | output | 1 | Sync pattern has been found |

## Verification
The assertions assume that `wide_mode` does not change after reset. They also assume that `rst` is asserted before the first edge, so the `$past` terms of the sync properties never refer to cycles before the design was cleared. The bench changes `wide_mode` only while `rst` is high. It drives `in_valid` with data that cannot be taken while `in_ready` is low, to show that such units are dropped rather than stored. All inputs change one nanosecond after a rising edge.

// File: rtl/cfgport_ingress_pkg.sv
package cfgport_ingress_pkg;
  localparam int unsigned WORD_BITS = 32;
  localparam logic [WORD_BITS-1:0] SYNC_PATTERN = 32'hAA99_5566;
endpackage

// File: rtl/cfgport_byte_swap.sv
module cfgport_byte_swap #(
  parameter int unsigned BUS_W = 16
) (
  input  logic [BUS_W-1:0] raw,
  output logic [BUS_W-1:0] swapped
);
  localparam int unsigned N_BYTES = BUS_W / 8;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign swapped[b*8 + i] = raw[b*8 + 7 - i];
    end
  end
endmodule

// File: rtl/cfgport_sync_hunt.sv
module cfgport_sync_hunt
  import cfgport_ingress_pkg::*;
#(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned WORD_W = WORD_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide,
  input  logic             take,
  input  logic [BUS_W-1:0] unit,
  output logic             synced
);
  logic [WORD_W-1:0] win_q;
  logic [WORD_W-1:0] win_n;

  always_comb begin
    if (wide) win_n = {win_q[WORD_W-BUS_W-1:0], unit};
    else      win_n = {win_q[WORD_W-9:0], unit[7:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      synced <= 1'b0;
    end else if (take && !synced) begin
      win_q <= win_n;
      if (win_n == SYNC_PATTERN[WORD_W-1:0]) synced <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgport_word_pack.sv
module cfgport_word_pack #(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide,
  input  logic              take,
  input  logic [BUS_W-1:0]  unit,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  localparam int unsigned NARROW_UNITS = WORD_W / 8;
  localparam int unsigned WIDE_UNITS   = WORD_W / BUS_W;
  localparam int unsigned CNT_W        = $clog2(NARROW_UNITS);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] acc_n;
  logic              last;

  always_comb begin
    if (wide) acc_n = {acc_q[WORD_W-BUS_W-1:0], unit};
    else      acc_n = {acc_q[WORD_W-9:0], unit[7:0]};
    last = wide ? (cnt_q == CNT_W'(WIDE_UNITS - 1))
                : (cnt_q == CNT_W'(NARROW_UNITS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        acc_q <= acc_n;
        if (last) begin
          cnt_q     <= '0;
          out_data  <= acc_n;
          out_valid <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfgport_ingress.sv
module cfgport_ingress
  import cfgport_ingress_pkg::*;
#(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned WORD_W = WORD_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BUS_W-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              synced
);
  logic [BUS_W-1:0] unit;
  logic             take;

  assign in_ready = !(out_valid && !out_ready);
  assign take     = in_valid && in_ready;

  cfgport_byte_swap #(.BUS_W(BUS_W)) u_swap (
    .raw     (in_data),
    .swapped (unit)
  );

  cfgport_sync_hunt #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_hunt (
    .clk    (clk),
    .rst    (rst),
    .wide   (wide_mode),
    .take   (take),
    .unit   (unit),
    .synced (synced)
  );

  cfgport_word_pack #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .wide      (wide_mode),
    .take      (take && synced),
    .unit      (unit),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: rtl/cfgport_ingress_chk.sv
module cfgport_ingress_chk #(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wide_mode,
  input logic              in_valid,
  input logic              in_ready,
  input logic [BUS_W-1:0]  in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              synced
);
  logic acc_ok;
  assign acc_ok = !rst && in_valid && in_ready;

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !synced && !out_valid);

  p_sync_narrow_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(acc_ok && !wide_mode && in_data[7:0] == 8'h55, 3) &&
     $past(acc_ok && !wide_mode && in_data[7:0] == 8'h99, 2) &&
     $past(acc_ok && !wide_mode && in_data[7:0] == 8'hAA, 1) &&
     acc_ok && !wide_mode && in_data[7:0] == 8'h66) |=> synced);

  p_sync_wide_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(acc_ok && wide_mode && in_data == 16'h5599) &&
     acc_ok && wide_mode && in_data == 16'hAA66) |=> synced);

  p_no_fwd_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(synced) |-> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));

  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    synced |=> synced);

  p_valid_needs_sync_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> synced);
endmodule

bind cfgport_ingress cfgport_ingress_chk #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wide_mode (wide_mode),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .synced    (synced)
);

// File: tb/cfgport_ingress_tb_top.sv
`timescale 1ns/1ps
module cfgport_ingress_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = 16'h0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        synced;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cfgport_ingress dut_i (
    .clk(clk), .rst(rst), .wide_mode(wide_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .synced(synced)
  );

  // Vector table: mode, four bus units (wide uses first two), expected word.
  localparam int NV = 4;
  localparam logic        V_WIDE [NV] = '{1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [15:0] V_U0   [NV] = '{16'h01, 16'h34, 16'h0180, 16'h1234};
  localparam logic [15:0] V_U1   [NV] = '{16'h80, 16'hA5, 16'h0F12, 16'hC300};
  localparam logic [15:0] V_U2   [NV] = '{16'h0F, 16'hFF, 16'h0, 16'h0};
  localparam logic [15:0] V_U3   [NV] = '{16'h12, 16'h00, 16'h0, 16'h0};
  localparam logic [31:0] V_EXP  [NV] = '{32'h8001F048, 32'h2CA5FF00,
                                          32'h8001F048, 32'h482CC300};

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] d);
    in_valid = 1'b1;
    in_data  = d;
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_data  = 16'hFFFF;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset(input logic w);
    rst = 1'b1;
    wide_mode = w;
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic send_sync(input logic w);
    if (w) begin send(16'h5599); send(16'hAA66); end
    else begin send(16'h55); send(16'h99); send(16'hAA); send(16'h66); end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      finish_run();
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    check(synced == 1'b0, "R1 synced", 32'(synced), 0);
    check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 1);
    rst = 1'b0;

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      logic [15:0] u [4];
      int nu;
      u[0] = V_U0[v]; u[1] = V_U1[v]; u[2] = V_U2[v]; u[3] = V_U3[v];
      nu = V_WIDE[v] ? 2 : 4;
      do_reset(V_WIDE[v]);
      send_sync(V_WIDE[v]);
      check(synced == 1'b1, V_WIDE[v] ? "R5 sync found" : "R4 sync found", 32'(synced), 1);
      check(out_valid == 1'b0, "R6 sync not forwarded", 32'(out_valid), 0);
      for (int k = 0; k < nu; k++) begin
        send(u[k]);
        if (k < nu - 1)
          check(out_valid == 1'b0, "R7 word incomplete", 32'(out_valid), 0);
      end
      check(out_valid == 1'b1, "R7 word valid", 32'(out_valid), 1);
      check(out_data == V_EXP[v], V_WIDE[v] ? "R3 wide swap" : "R2 narrow swap",
            out_data, V_EXP[v]);
      idle(1);
    end

    // R4 / R11: misaligned narrow sync with a partial match first
    do_reset(1'b0);
    send(16'hA5); send(16'h55); send(16'h99); send(16'h55); send(16'h99);
    check(synced == 1'b0, "R4 partial no sync", 32'(synced), 0);
    send(16'hAA);
    check(synced == 1'b0, "R4 one short", 32'(synced), 0);
    check(out_valid == 1'b0, "R11 no output before sync", 32'(out_valid), 0);
    send(16'h66);
    check(synced == 1'b1, "R4 misaligned sync", 32'(synced), 1);

    // R8: idle gaps with garbage data
    send(16'h01); idle(3); send(16'h80); idle(2); send(16'h0F);
    check(out_valid == 1'b0, "R8 gaps not counted", 32'(out_valid), 0);
    idle(2);
    send(16'h12);
    check(out_data == 32'h8001F048 && out_valid, "R8 gap word", out_data, 32'h8001F048);
    idle(1);

    // R9: back-pressure
    out_ready = 1'b0;
    send(16'h34); send(16'hA5); send(16'hFF); send(16'h00);
    check(in_ready == 1'b0, "R9 in_ready low", 32'(in_ready), 0);
    check(out_data == 32'h2CA5FF00, "R9 word", out_data, 32'h2CA5FF00);
    in_valid = 1'b1; in_data = 16'h01;
    idle(3);
    check(out_valid == 1'b1, "R9 valid held", 32'(out_valid), 1);
    check(out_data == 32'h2CA5FF00, "R9 data held", out_data, 32'h2CA5FF00);
    in_valid = 1'b0; out_ready = 1'b1;
    idle(1);
    check(out_valid == 1'b0, "R9 valid cleared", 32'(out_valid), 0);
    send(16'h12); send(16'h34); send(16'hA5); send(16'hC3);
    check(out_data == 32'h482CA5C3, "R8 stalled unit dropped", out_data, 32'h482CA5C3);

    // R10: pattern after sync is data, synced stays
    do_reset(1'b1);
    send_sync(1'b1);
    send_sync(1'b1);
    check(out_valid && out_data == 32'hAA995566, "R10 pattern forwarded", out_data, 32'hAA995566);
    check(synced == 1'b1, "R10 synced sticky", 32'(synced), 1);

    // R5: misaligned wide sync
    do_reset(1'b1);
    send(16'h1234);
    send_sync(1'b1);
    check(synced == 1'b1, "R5 sync after junk", 32'(synced), 1);

    // R1: reset after activity
    do_reset(1'b0);
    check(synced == 1'b0 && out_valid == 1'b0, "R1 reset clears", 32'({synced, out_valid}), 0);

    finished = 1'b1;
    finish_run();
  end
endmodule